// File: doc/BRIEF.md
# Interrupt CPU Interface

This block is the per-processor front end of an interrupt controller. The distributor presents it with one candidate: the most urgent pending interrupt, as an ID and an 8-bit priority. The block decides whether that candidate may reach the processor. It then raises a level interrupt line and gives software a 32-bit register window. Through that window software sets a priority threshold, takes interrupts and reports that their handling is finished.

Taking an interrupt is done by reading the acknowledge register, and that read has side effects. It returns the candidate ID. It pushes the candidate onto a small stack of active interrupts, which raises the running priority. It also sends a one-cycle acknowledge strobe back to the distributor, so the distributor can move that ID from pending to active. When software writes the matching ID to the completion register, the stack is popped, the previous running level returns, and a completion strobe tells the distributor that the ID is inactive again. A lower priority value is more urgent.

Register offsets: 0x00 control (bit 0 enable), 0x04 priority threshold, 0x08 binary point (storage only), 0x0C acknowledge, 0x10 completion, 0x14 running priority, 0x18 peek.

Top module: `irqc_cpu_port`

## Requirements
- R1: After reset, control reads 0, the threshold reads 0, binary point reads 0, running priority reads 0xFF and peek reads 1023. Control bit 0, threshold bits 7:0 and binary point bits 2:0 are written by bus writes and read back at their offsets, with the other bits reading 0.
- R2: `irq_out` is a registered copy of (enable AND candidate eligible), one cycle late. It is low whenever control bit 0 was clear in the previous cycle.
- R3: A candidate is eligible only when all of these hold: `cand_valid` is high, its priority is strictly below the threshold, its priority is strictly below the running priority, and the active stack is not full. A threshold of 255 admits priorities 0 to 254. A threshold of 0 admits nothing.
- R4: An acknowledge read (0x0C) made while nothing is eligible, or while control bit 0 is clear, returns 1023 in bits 9:0. It raises no strobe and changes no state.
- R5: An acknowledge read made while the candidate is eligible returns its ID in bits 9:0, with the upper bits 0. In the next cycle, `ack_strobe` is high for one cycle with `ack_id` equal to that ID, and the running priority equals the candidate's priority.
- R6: Running priority (0x14, bits 7:0) is the priority of the most recently acknowledged interrupt that is still active, or 0xFF when none is active.
- R7: A write to 0x10 whose bits 9:0 equal the ID on top of the active stack pops that entry. In the next cycle `eoi_strobe` is high for one cycle with `eoi_id` equal to that ID, and the running priority returns to the level below. A write that does not match, or a write made while the stack is empty, changes nothing and raises no strobe.
- R8: The active stack holds DEPTH (default 4) entries. While it is full, no candidate is eligible.
- R9: A read of 0x18 returns the same value an acknowledge read would return at that moment, with no side effect on the stack or the strobes.
- R10: The binary point value has no effect on eligibility.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_strobe | output | 1 | One-cycle pulse: `ack_id` was taken |
| ack_id | output | 10 | ID that was acknowledged |
| eoi_strobe | output | 1 | One-cycle pulse: `eoi_id` completed |
| eoi_id | output | 10 | ID that completed |

## Verification
The state hardest to reach from the ports is a full active stack. The bench gets there through a chain of acknowledges, each one offering a candidate strictly more urgent than the one before. With the stack full, it offers a still more urgent candidate and checks that this candidate is refused. It then completes the entries in reverse order, with a mismatched completion placed in between. The threshold-against-priority relation is swept over all 256 priorities, for several threshold values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BINPT_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_BINPT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DONE  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RUN   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PEEK  = 8'h18;

  localparam logic [ID_W-1:0]   SPURIOUS_ID = '1;
  localparam logic [PRIO_W-1:0] IDLE_PRIO   = '1;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } irq_entry_t;
endpackage

// File: rtl/irqc_prio_stack.sv
module irqc_prio_stack
  import irqc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  irq_entry_t       push_entry,
  input  logic             pop,
  output irq_entry_t       top_entry,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] level
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  irq_entry_t       ent_q [DEPTH];
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign level   = cnt_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty && !push;

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + 1'b1;
    else if (do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = do_push && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ent_q[i] <= '0;
      else if (slot_we) ent_q[i] <= push_entry;
    end
  end

  always_comb begin
    top_entry.id   = SPURIOUS_ID;
    top_entry.prio = IDLE_PRIO;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) top_entry = ent_q[i];
    end
  end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
  import irqc_pkg::*;
(
  input  logic              enable,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] mask,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              stack_full,
  output logic              grant_ok,
  output logic [ID_W-1:0]   best_id
);
  logic below_mask, below_run;

  assign below_mask = (cand_prio < mask);
  assign below_run  = (cand_prio < run_prio);
  assign grant_ok   = enable && cand_valid && below_mask && below_run && !stack_full;
  assign best_id    = grant_ok ? cand_id : SPURIOUS_ID;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [ID_W-1:0]    best_id,
  input  logic [PRIO_W-1:0]  run_prio,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               ctrl_en,
  output logic [PRIO_W-1:0]  mask,
  output logic               ack_rd,
  output logic               done_wr
);
  logic               en_q, en_d;
  logic [PRIO_W-1:0]  mask_q, mask_d;
  logic [BINPT_W-1:0] bp_q, bp_d;
  logic               wr_ctrl, wr_mask, wr_bp;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  assign wr_mask = bus_sel && bus_wr && (bus_addr == OFS_MASK);
  assign wr_bp   = bus_sel && bus_wr && (bus_addr == OFS_BINPT);
  assign ack_rd  = bus_sel && !bus_wr && (bus_addr == OFS_ACK);
  assign done_wr = bus_sel && bus_wr && (bus_addr == OFS_DONE);

  always_comb begin
    en_d   = wr_ctrl ? bus_wdata[0] : en_q;
    mask_d = wr_mask ? bus_wdata[PRIO_W-1:0] : mask_q;
    bp_d   = wr_bp   ? bus_wdata[BINPT_W-1:0] : bp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      bp_q   <= '0;
    end else begin
      en_q   <= en_d;
      mask_q <= mask_d;
      bp_q   <= bp_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:          bus_rdata = DATA_W'(en_q);
      OFS_MASK:          bus_rdata = DATA_W'(mask_q);
      OFS_BINPT:         bus_rdata = DATA_W'(bp_q);
      OFS_ACK, OFS_PEEK: bus_rdata = DATA_W'(best_id);
      OFS_RUN:           bus_rdata = DATA_W'(run_prio);
      default:           bus_rdata = '0;
    endcase
  end

  assign ctrl_en = en_q;
  assign mask    = mask_q;
endmodule

// File: rtl/irqc_cpu_port.sv
module irqc_cpu_port
  import irqc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              irq_out,
  output logic              ack_strobe,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_strobe,
  output logic [ID_W-1:0]   eoi_id
);
  logic              ctrl_en, ack_rd, done_wr, grant_ok;
  logic [PRIO_W-1:0] mask, run_prio;
  logic [ID_W-1:0]   best_id, wdata_id;
  irq_entry_t        top_entry, push_entry;
  logic              empty, full, push, pop;
  logic [CNT_W-1:0]  level;

  logic              irq_q, irq_d;
  logic              ack_stb_q, ack_stb_d, eoi_stb_q, eoi_stb_d;
  logic [ID_W-1:0]   ack_id_q, ack_id_d, eoi_id_q, eoi_id_d;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .best_id(best_id),
    .run_prio(run_prio), .bus_rdata(bus_rdata), .ctrl_en(ctrl_en),
    .mask(mask), .ack_rd(ack_rd), .done_wr(done_wr)
  );

  irqc_gate u_gate (
    .enable(ctrl_en), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .mask(mask), .run_prio(run_prio),
    .stack_full(full), .grant_ok(grant_ok), .best_id(best_id)
  );

  irqc_prio_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .push_entry(push_entry),
    .pop(pop), .top_entry(top_entry), .empty(empty), .full(full),
    .level(level)
  );

  assign run_prio        = top_entry.prio;
  assign wdata_id        = bus_wdata[ID_W-1:0];
  assign push_entry.id   = cand_id;
  assign push_entry.prio = cand_prio;
  assign push            = ack_rd && grant_ok;
  assign pop             = done_wr && !empty && (wdata_id == top_entry.id);

  always_comb begin
    irq_d     = ctrl_en && grant_ok;
    ack_stb_d = push;
    ack_id_d  = push ? cand_id : ack_id_q;
    eoi_stb_d = pop;
    eoi_id_d  = pop ? top_entry.id : eoi_id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      ack_stb_q <= 1'b0;
      ack_id_q  <= '0;
      eoi_stb_q <= 1'b0;
      eoi_id_q  <= '0;
    end else begin
      irq_q     <= irq_d;
      ack_stb_q <= ack_stb_d;
      ack_id_q  <= ack_id_d;
      eoi_stb_q <= eoi_stb_d;
      eoi_id_q  <= eoi_id_d;
    end
  end

  assign irq_out    = irq_q;
  assign ack_strobe = ack_stb_q;
  assign ack_id     = ack_id_q;
  assign eoi_strobe = eoi_stb_q;
  assign eoi_id     = eoi_id_q;
endmodule

// File: rtl/irqc_cpu_port_chk.sv
module irqc_cpu_port_chk
  import irqc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_en,
  input logic              irq_out,
  input logic              ack_rd,
  input logic              done_wr,
  input logic              grant_ok,
  input logic [PRIO_W-1:0] cand_prio,
  input logic [PRIO_W-1:0] run_prio,
  input logic              ack_strobe,
  input logic              eoi_strobe,
  input logic [ID_W-1:0]   wdata_id,
  input logic [ID_W-1:0]   top_id,
  input logic              empty,
  input logic [CNT_W-1:0]  level
);
  AST_IRQ_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !irq_out); // R2

  AST_SPURIOUS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !grant_ok) |=> (!ack_strobe && $stable(run_prio))); // R4

  AST_ACK_SETS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && grant_ok) |=> (ack_strobe && run_prio == $past(cand_prio))); // R5

  AST_IDLE_RUNNING_FF: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (run_prio == IDLE_PRIO)); // R6

  AST_EOI_MISMATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr && (empty || wdata_id != top_id)) |=> (!eoi_strobe && $stable(run_prio))); // R7

  AST_STACK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R8

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_strobe && eoi_strobe)); // R5
endmodule

bind irqc_cpu_port irqc_cpu_port_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .irq_out(irq_out),
  .ack_rd(ack_rd), .done_wr(done_wr), .grant_ok(grant_ok),
  .cand_prio(cand_prio), .run_prio(run_prio), .ack_strobe(ack_strobe),
  .eoi_strobe(eoi_strobe), .wdata_id(wdata_id), .top_id(top_entry.id),
  .empty(empty), .level(level)
);

// File: tb/irqc_cpu_port_tb_top.sv
`timescale 1ns/1ps
module irqc_cpu_port_tb_top;
  localparam int SPUR = 1023;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        irq_out, ack_strobe, eoi_strobe;
  logic [9:0]  ack_id, eoi_id;

  int checks = 0, bad = 0, cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irqc_cpu_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
    .irq_out(irq_out), .ack_strobe(ack_strobe), .ack_id(ack_id),
    .eoi_strobe(eoi_strobe), .eoi_id(eoi_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p);
    @(negedge clk);
    cand_valid = v; cand_id = id; cand_prio = p;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] masks [5] = '{8'h00, 8'h01, 8'h80, 8'hFE, 8'hFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h00, d); check("R1 ctrl reset", d, 0);
    rd(8'h04, d); check("R1 mask reset", d, 0);
    rd(8'h08, d); check("R1 binpt reset", d, 0);
    rd(8'h14, d); check("R1 running reset", d, 32'hFF);
    rd(8'h18, d); check("R1 peek reset", d, SPUR);
    check("R1 irq reset", irq_out, 0);

    // R1 read-back with upper bits dropped
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R1 ctrl rb", d, 1);
    wr(8'h04, 32'h1234_56A5); rd(8'h04, d); check("R1 mask rb", d, 32'hA5);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); check("R1 binpt rb", d, 7);

    // R3 R10 sweep of threshold against every priority, binpt=7
    foreach (masks[k]) begin
      wr(8'h04, {24'h0, masks[k]});
      for (int p = 0; p < 256; p++) begin
        logic pass;
        pass = (p < masks[k]);
        offer(1'b1, 10'(p + 100), 8'(p));
        rd(8'h18, d);
        check("R3 R10 R9 peek sweep", d, pass ? 32'(p + 100) : SPUR);
        check("R2 R3 irq sweep", irq_out, pass);
        check("R9 peek no strobe", ack_strobe, 0);
      end
    end

    // R3 candidate not valid
    wr(8'h04, 32'hFF);
    offer(1'b0, 10'd7, 8'h10);
    rd(8'h0C, d); check("R3 R4 invalid spurious", d, SPUR);
    check("R4 no strobe", ack_strobe, 0);

    // R2 R4 disabled
    wr(8'h00, 0);
    offer(1'b1, 10'd7, 8'h10);
    @(negedge clk); check("R2 disabled irq low", irq_out, 0);
    rd(8'h0C, d); check("R4 disabled spurious", d, SPUR);
    check("R4 disabled no strobe", ack_strobe, 0);
    rd(8'h14, d); check("R4 running unchanged", d, 32'hFF);
    wr(8'h00, 1);
    @(negedge clk); check("R2 enabled irq high", irq_out, 1);

    // R5 R6 R7 nesting
    offer(1'b1, 10'd40, 8'h80);
    rd(8'h0C, d); check("R5 ack id", d, 40);
    check("R5 ack strobe", ack_strobe, 1); check("R5 ack_id", ack_id, 40);
    @(negedge clk); check("R5 strobe one cycle", ack_strobe, 0);
    rd(8'h14, d); check("R6 running 80", d, 32'h80);
    offer(1'b1, 10'd41, 8'h80);
    rd(8'h18, d); check("R3 equal prio blocked", d, SPUR);
    check("R2 irq low equal", irq_out, 0);
    offer(1'b1, 10'd42, 8'h40);
    rd(8'h0C, d); check("R5 nested ack", d, 42);
    rd(8'h14, d); check("R6 running 40", d, 32'h40);
    wr(8'h10, 40); check("R7 mismatch no strobe", eoi_strobe, 0);
    rd(8'h14, d); check("R7 mismatch running kept", d, 32'h40);
    wr(8'h10, 42); check("R7 eoi strobe", eoi_strobe, 1); check("R7 eoi_id", eoi_id, 42);
    rd(8'h14, d); check("R7 running restored", d, 32'h80);
    check("R7 strobe one cycle", eoi_strobe, 0);
    wr(8'h10, 40); check("R7 eoi outer", eoi_id, 40);
    rd(8'h14, d); check("R6 idle again", d, 32'hFF);
    wr(8'h10, 40); check("R7 empty eoi ignored", eoi_strobe, 0);

    // R8 fill the stack
    for (int i = 0; i < 4; i++) begin
      offer(1'b1, 10'(200 + i), 8'(8'h70 - 8'h10 * i));
      rd(8'h0C, d); check("R8 fill ack", d, 32'(200 + i));
    end
    rd(8'h14, d); check("R8 running at top", d, 32'h40);
    offer(1'b1, 10'd300, 8'h10);
    rd(8'h18, d); check("R8 full peek", d, SPUR);
    check("R8 full irq low", irq_out, 0);
    rd(8'h0C, d); check("R8 full ack spurious", d, SPUR);
    check("R8 full no strobe", ack_strobe, 0);
    wr(8'h10, 201); check("R7 mid mismatch", eoi_strobe, 0);
    for (int i = 3; i >= 0; i--) begin
      offer(1'b0, 10'd0, 8'h00);
      wr(8'h10, 32'(200 + i));
      check("R7 unwind strobe", eoi_strobe, 1);
      check("R7 unwind id", eoi_id, 32'(200 + i));
      rd(8'h14, d);
      check("R6 R7 unwind running", d, i == 0 ? 32'hFF : 32'(8'h70 - 8'h10 * (i - 1)));
    end

    finish_run();
  end
endmodule